// File: doc/BRIEF.md
# Two-Wire Bus Watcher with Dual Address Match

This block listens to the data and clock lines of a two-wire serial bus without ever driving them. Both lines first pass through a synchroniser. The block then finds start and stop conditions, tracks whether the bus is occupied, and examines the first byte that follows every start.

It compares that byte with two separately enabled 7-bit slave addresses and with the all-zero general-call byte. The result appears as two sticky match flags, which a slave controller can use to decide whether to take part in the transfer. Software can clear the occupancy flag by writing a one to it. Turning the module off forces every flag to zero.

Top module: `i2c_addr_watch`

## Requirements
- R1: After reset, and in the cycle after `enable` is sampled low, `busy`, `addr_match` and `gcall_match` are all 0. They stay 0 for as long as `enable` is low, whatever the lines do.
- R2: While enabled, `busy` becomes 1 whenever the synchronised SDA or the synchronised SCL is low. Either line being low is enough.
- R3: A start condition sets `busy`. A start is SDA going from 1 to 0 while SCL stays 1.
- R4: A stop condition clears `busy`. A stop is SDA going from 0 to 1 while SCL stays 1.
- R5: A one-cycle `busy_clr` pulse clears `busy` in the next cycle. If a line is still low at that point, `busy` is set again in the cycle after.
- R6: Data bits are taken on SCL rising edges, most significant bit first. When the 8 bits of the first byte after a start have arrived, `addr_match` becomes 1 if bits 7..1 of that byte equal `addr_a` and `addr_a_en` is 1.
- R7: In the same way, `addr_match` becomes 1 if bits 7..1 of the first byte equal `addr_b` and `addr_b_en` is 1. The read/write bit (bit 0) is not compared.
- R8: `addr_match` stays 0 when the first byte matches an address whose enable is 0, or when it matches neither address.
- R9: `gcall_match` becomes 1 only if `gcall_en` is 1 and all 8 bits of the first byte are 0. A byte of 01h does not set it.
- R10: Both match flags clear in the cycle after any start (including a repeated start) or any stop is detected.
- R11: Only the first byte after a start is compared. Bytes that follow it never set a match flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable; when 0 all flags are held at 0 |
| sda_in | input | 1 | Raw serial data line |
| scl_in | input | 1 | Raw serial clock line |
| addr_a | input | 7 | First slave address |
| addr_a_en | input | 1 | Enables comparison with `addr_a` |
| addr_b | input | 7 | Second slave address |
| addr_b_en | input | 1 | Enables comparison with `addr_b` |
| gcall_en | input | 1 | Enables general-call detection |
| busy_clr | input | 1 | Write-one strobe that clears `busy` |
| busy | output | 1 | Bus occupied flag |
| addr_match | output | 1 | First byte matched an enabled slave address |
| gcall_match | output | 1 | First byte was the general-call byte |

## Verification
Some rules are checked on every cycle: flags are forced off by disable, `busy` follows a low line or a start, stops and clear strobes drop `busy`, start and stop clear the match flags, and a general-call match never appears without its enable. Other behaviour shows only in the bench's bus scenarios: MSB-first assembly of the byte, the choice between the two addresses and their enables, the ignored read/write bit, the fact that later bytes are not compared, and `busy` re-setting after a clear while a line is still low.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

  // Line events found on the synchronised bus, valid for one cycle
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);

  logic [LINES-1:0] pipe [STAGES];

  // The idle bus is pulled high, so every stage resets to 1
  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '1;
    else     pipe[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '1;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_watch_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sda,
  input  logic     scl,
  output bus_evt_t evt
);

  logic sda_q, scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda;
      scl_q <= scl;
    end
  end

  // SCL must be high in both samples for a data edge to count as a condition
  always_comb begin
    evt.start    = sda_q && !sda && scl_q && scl;
    evt.stop     = !sda_q && sda && scl_q && scl;
    evt.scl_rise = !scl_q && scl;
  end

endmodule

// File: rtl/i2c_addr_capture.sv
module i2c_addr_capture
  import i2c_watch_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  bus_evt_t          evt,
  input  logic              sda,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              addr_a_en,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              addr_b_en,
  input  logic              gcall_en,
  output logic              hit_addr,
  output logic              hit_gcall
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              active;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] shreg;
  logic              last_bit;
  logic [BYTE_W-1:0] first_byte;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      active  <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (evt.start) begin
      active  <= 1'b1;
      bit_cnt <= '0;
    end else if (evt.stop) begin
      active  <= 1'b0;
    end else if (evt.scl_rise && active) begin
      shreg   <= {shreg[ADDR_W-2:0], sda};
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == LAST_BIT) active <= 1'b0;
    end
  end

  always_comb begin
    last_bit   = active && evt.scl_rise && (bit_cnt == LAST_BIT);
    first_byte = {shreg, sda};
    hit_addr   = last_bit &&
                 ((addr_a_en && (first_byte[BYTE_W-1:1] == addr_a)) ||
                  (addr_b_en && (first_byte[BYTE_W-1:1] == addr_b)));
    hit_gcall  = last_bit && gcall_en && (first_byte == '0);
  end

endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
  import i2c_watch_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              sda_in,
  input  logic              scl_in,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              addr_a_en,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              addr_b_en,
  input  logic              gcall_en,
  input  logic              busy_clr,
  output logic              busy,
  output logic              addr_match,
  output logic              gcall_match
);

  logic [1:0] line_s;
  logic       sda_s, scl_s;
  bus_evt_t   evt;
  logic       hit_addr, hit_gcall;
  logic       start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({sda_in, scl_in}),
    .dout (line_s)
  );

  assign sda_s = line_s[1];
  assign scl_s = line_s[0];

  i2c_cond_detect u_cond (
    .clk (clk),
    .rst (rst),
    .sda (sda_s),
    .scl (scl_s),
    .evt (evt)
  );

  assign start_det = evt.start;
  assign stop_det  = evt.stop;

  i2c_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .evt       (evt),
    .sda       (sda_s),
    .addr_a    (addr_a),
    .addr_a_en (addr_a_en),
    .addr_b    (addr_b),
    .addr_b_en (addr_b_en),
    .gcall_en  (gcall_en),
    .hit_addr  (hit_addr),
    .hit_gcall (hit_gcall)
  );

  // Clearing wins over setting in the same cycle; a low line re-sets afterwards
  always_ff @(posedge clk) begin
    if (rst || !enable)            busy <= 1'b0;
    else if (stop_det || busy_clr) busy <= 1'b0;
    else if (!sda_s || !scl_s || start_det) busy <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      addr_match  <= 1'b0;
      gcall_match <= 1'b0;
    end else if (start_det || stop_det) begin
      addr_match  <= 1'b0;
      gcall_match <= 1'b0;
    end else begin
      if (hit_addr)  addr_match  <= 1'b1;
      if (hit_gcall) gcall_match <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_addr_watch_chk.sv
module i2c_addr_watch_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic busy_clr,
  input logic gcall_en,
  input logic sda_s,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic busy,
  input logic addr_match,
  input logic gcall_match
);

  // R1
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!busy && !addr_match && !gcall_match));

  // R2
  low_line_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !busy_clr && !stop_det && (!sda_s || !scl_s)) |=> busy);

  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !busy_clr && start_det) |=> busy);

  // R4
  stop_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);

  // R5
  wr_clear_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_clr |=> !busy);

  // R10
  cond_clears_match_chk: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |=> (!addr_match && !gcall_match));

  // R9
  gcall_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gcall_match) |-> $past(gcall_en));

endmodule

bind i2c_addr_watch i2c_addr_watch_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .busy_clr    (busy_clr),
  .gcall_en    (gcall_en),
  .sda_s       (sda_s),
  .scl_s       (scl_s),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .busy        (busy),
  .addr_match  (addr_match),
  .gcall_match (gcall_match)
);

// File: tb/i2c_addr_watch_tb.sv
`timescale 1ns/1ps
module i2c_addr_watch_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       sda_in = 1'b1;
  logic       scl_in = 1'b1;
  logic [6:0] addr_a = 7'h5A;
  logic       addr_a_en = 1'b0;
  logic [6:0] addr_b = 7'h23;
  logic       addr_b_en = 1'b0;
  logic       gcall_en = 1'b0;
  logic       busy_clr = 1'b0;
  logic       busy, addr_match, gcall_match;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    logic  b;
    logic  a;
    logic  g;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  i2c_addr_watch u_dut (
    .clk(clk), .rst(rst), .enable(enable), .sda_in(sda_in), .scl_in(scl_in),
    .addr_a(addr_a), .addr_a_en(addr_a_en), .addr_b(addr_b), .addr_b_en(addr_b_en),
    .gcall_en(gcall_en), .busy_clr(busy_clr),
    .busy(busy), .addr_match(addr_match), .gcall_match(gcall_match)
  );

  // Monitor: compares the design's flags with each queued expectation
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (busy !== e.b || addr_match !== e.a || gcall_match !== e.g) begin
        bad++;
        $display("FAIL %s: got busy=%b addr=%b gcall=%b expected busy=%b addr=%b gcall=%b",
                 e.tag, busy, addr_match, gcall_match, e.b, e.a, e.g);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_flags(string tag, logic b, logic a, logic g);
    exp_t e;
    e.tag = tag; e.b = b; e.a = a; e.g = g;
    sb_q.push_back(e);
    tick(1);
  endtask

  // Settle margin covers synchroniser, edge register and flag register
  task automatic lines(logic d, logic c);
    sda_in = d;
    scl_in = c;
    tick(6);
  endtask

  task automatic send_start();
    lines(1'b1, scl_in);
    lines(1'b1, 1'b1);
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
  endtask

  task automatic send_stop();
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      lines(v[i], 1'b0);
      lines(v[i], 1'b1);
      lines(v[i], 1'b0);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    expect_flags("R1 reset", 0, 0, 0);
    enable = 1'b1;
    tick(6);
    expect_flags("R2 idle high", 0, 0, 0);

    // R2: SCL low alone
    lines(1'b1, 1'b0);
    expect_flags("R2 scl low", 1, 0, 0);
    lines(1'b1, 1'b1);
    expect_flags("R2 kept", 1, 0, 0);
    // R5: clear with both lines high
    busy_clr = 1'b1; tick(1); busy_clr = 1'b0;
    expect_flags("R5 cleared", 0, 0, 0);
    // R5: clear while SDA held low with SCL low: re-sets after one cycle
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0);
    expect_flags("R2 sda low", 1, 0, 0);
    busy_clr = 1'b1; tick(1); busy_clr = 1'b0;
    expect_flags("R5 clear pulse", 0, 0, 0);
    expect_flags("R5 re-set", 1, 0, 0);
    send_stop();
    expect_flags("R4 stop", 0, 0, 0);

    // R3 / R6
    addr_a_en = 1'b1;
    send_start();
    expect_flags("R3 start", 1, 0, 0);
    send_byte({7'h5A, 1'b0});
    expect_flags("R6 addr_a", 1, 1, 0);
    // R10 repeated start, R7
    addr_a_en = 1'b0; addr_b_en = 1'b1;
    send_start();
    expect_flags("R10 rep start", 1, 0, 0);
    send_byte({7'h23, 1'b1});
    expect_flags("R7 addr_b", 1, 1, 0);
    send_stop();
    expect_flags("R10 R4 stop", 0, 0, 0);

    // R8
    send_start();
    send_byte({7'h5A, 1'b0});
    expect_flags("R8 disabled addr", 1, 0, 0);
    addr_a_en = 1'b1;
    send_start();
    send_byte(8'h3C);
    expect_flags("R8 mismatch", 1, 0, 0);

    // R11: second byte matches but is not compared
    send_start();
    send_byte(8'h11);
    send_byte({7'h5A, 1'b1});
    expect_flags("R11 second byte", 1, 0, 0);
    send_stop();

    // R9
    gcall_en = 1'b1;
    send_start();
    send_byte(8'h00);
    expect_flags("R9 gcall", 1, 0, 1);
    send_stop();
    expect_flags("R10 gcall stop", 0, 0, 0);
    send_start();
    send_byte(8'h01);
    expect_flags("R9 byte 01", 1, 0, 0);
    gcall_en = 1'b0;
    send_start();
    send_byte(8'h00);
    expect_flags("R9 gcall off", 1, 0, 0);

    // R1: disable while flags are set and lines low
    send_start();
    send_byte({7'h5A, 1'b0});
    expect_flags("R6 before disable", 1, 1, 0);
    enable = 1'b0;
    tick(1);
    expect_flags("R1 disabled", 0, 0, 0);
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    expect_flags("R1 held off", 0, 0, 0);

    tick(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule